// File: doc/BRIEF.md
# Wormhole Header Router

This block sits on the receive side of one link in a node that has three links. Each incoming packet is steered by its first byte. The input is a stream of tokens, and each token is either a data byte or one of two end-of-packet markers. When routing is on, the block reads the leading byte of each packet as a destination and compares it with three addresses: one for each of the two neighbouring links and one for the local node. It then drops that byte and forwards the rest of the packet to the chosen output. The rest of the packet runs up to and includes its end marker.

A destination that matches none of the addresses is not lost. The packet goes to the local output, and the block raises a one-cycle error interrupt unless a mask bit suppresses it. When routing is off, the block is a plain pipe into the local output. Every output is a registered valid/ready stage. Backpressure on the output currently in use stalls the input.

Top module: `hdr_router`

## Requirements
- R1: The header byte is compared with `addr_oth0`, `addr_oth1` and `addr_node`. When more than one address is equal to it, the node address wins over other-link 0, and other-link 0 wins over other-link 1.
- R2: The token kind is encoded as 2'b00 for a data byte, 2'b01 for EOP1 and 2'b10 for EOP2. With routing on, the header byte is removed. Every later token of the packet, including its end marker, appears on the selected output with its kind and byte unchanged and in order.
- R3: A header equal to `addr_oth0` delivers the packet on output port 0. A header equal to `addr_oth1` delivers it on output port 1.
- R4: A header equal to `addr_node` delivers the packet on the local output.
- R5: A header that matches no address delivers the packet on the local output. When `err_mask` is low, `err_irq` is high for exactly one cycle, on the cycle after the header is accepted.
- R6: When `err_mask` is high, an unmatched header still goes to the local output, but `err_irq` stays low.
- R7: An end marker that arrives where a header is expected produces no output token and no error.
- R8: The selected output is held until the end marker has been passed on. The next token after the end marker is decoded as a new header, even when it arrives in the next cycle. A payload byte equal to an address does not change the route.
- R9: While the selected output holds a token that is not accepted, the input is not accepted, and the output token stays stable.
- R10: With `route_en` low, every token, including the first of a packet, passes unchanged to the local output.
- R11: While reset is high, and on the first cycle after it, all output valids and `err_irq` are low. A token accepted at a clock edge appears on its output after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_en | input | 1 | Routing enable |
| err_mask | input | 1 | Suppresses the unmatched-destination interrupt |
| addr_oth0 | input | 8 | Address of neighbouring link 0 |
| addr_oth1 | input | 8 | Address of neighbouring link 1 |
| addr_node | input | 8 | Address of the local node |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Input token accepted |
| in_kind | input | 2 | Input token kind |
| in_data | input | 8 | Input data byte |
| o0_valid | output | 1 | Port 0 token valid |
| o0_ready | input | 1 | Port 0 sink ready |
| o0_kind | output | 2 | Port 0 token kind |
| o0_data | output | 8 | Port 0 byte |
| o1_valid | output | 1 | Port 1 token valid |
| o1_ready | input | 1 | Port 1 sink ready |
| o1_kind | output | 2 | Port 1 token kind |
| o1_data | output | 8 | Port 1 byte |
| loc_valid | output | 1 | Local token valid |
| loc_ready | input | 1 | Local sink ready |
| loc_kind | output | 2 | Local token kind |
| loc_data | output | 8 | Local byte |
| err_irq | output | 1 | Unmatched-destination interrupt pulse |

## Verification
The assertions assume that `route_en` and the address inputs change only between packets, and that kind 2'b11 never appears on the input. The bench sets these controls only while the input is idle and the outputs have drained, and it never drives the reserved kind. The assertions also assume that upstream holds a token steady until it is accepted. The bench meets this by changing input signals only on falling edges, and only after it has seen `in_ready` high for the current token.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    TK_DATA = 2'b00,
    TK_EOP1 = 2'b01,
    TK_EOP2 = 2'b10
  } tok_kind_e;

  localparam int NPORT      = 3;
  localparam int PORT_OTH0  = 0;
  localparam int PORT_OTH1  = 1;
  localparam int PORT_LOCAL = 2;
  localparam int PW         = $clog2(NPORT);
endpackage

// File: rtl/hdr_decode.sv
module hdr_decode
  import rt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] hdr,
  input  logic [AW-1:0] addr_oth0,
  input  logic [AW-1:0] addr_oth1,
  input  logic [AW-1:0] addr_node,
  output logic [PW-1:0] dest,
  output logic          miss
);
  always_comb begin
    miss = 1'b0;
    if (hdr == addr_node)      dest = PW'(PORT_LOCAL);
    else if (hdr == addr_oth0) dest = PW'(PORT_OTH0);
    else if (hdr == addr_oth1) dest = PW'(PORT_OTH1);
    else begin
      dest = PW'(PORT_LOCAL);
      miss = 1'b1;
    end
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R9: a token waiting on a stalled sink is neither dropped nor altered
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/hdr_router.sv
module hdr_router
  import rt_pkg::*;
#(
  parameter int DW = 8,
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          route_en,
  input  logic          err_mask,
  input  logic [DW-1:0] addr_oth0,
  input  logic [DW-1:0] addr_oth1,
  input  logic [DW-1:0] addr_node,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [KW-1:0] in_kind,
  input  logic [DW-1:0] in_data,
  output logic          o0_valid,
  input  logic          o0_ready,
  output logic [KW-1:0] o0_kind,
  output logic [DW-1:0] o0_data,
  output logic          o1_valid,
  input  logic          o1_ready,
  output logic [KW-1:0] o1_kind,
  output logic [DW-1:0] o1_data,
  output logic          loc_valid,
  input  logic          loc_ready,
  output logic [KW-1:0] loc_kind,
  output logic [DW-1:0] loc_data,
  output logic          err_irq
);
  localparam int TW = KW + DW;

  typedef enum logic {ST_HDR, ST_BODY} st_e;
  st_e st;

  logic [PW-1:0]    sel;
  logic [PW-1:0]    dec_dest;
  logic             dec_miss;
  logic [PW-1:0]    fwd_dest;
  logic             hdr_phase;
  logic             is_eop;
  logic             take;
  logic [NPORT-1:0] load;
  logic [NPORT-1:0] ovalid;
  logic [NPORT-1:0] oready;
  logic [NPORT-1:0] room;
  logic [TW-1:0]    odat [NPORT];

  hdr_decode #(.AW(DW)) u_dec (
    .hdr(in_data), .addr_oth0(addr_oth0), .addr_oth1(addr_oth1),
    .addr_node(addr_node), .dest(dec_dest), .miss(dec_miss)
  );

  assign oready = {loc_ready, o1_ready, o0_ready};

  always_comb begin
    is_eop    = (in_kind != TK_DATA);
    hdr_phase = route_en && (st == ST_HDR);
    fwd_dest  = route_en ? sel : PW'(PORT_LOCAL);
    room      = ~ovalid | oready;
    in_ready  = hdr_phase ? 1'b1 : room[fwd_dest];
    take      = in_valid && in_ready;
    load      = '0;
    if (take && !hdr_phase) load[fwd_dest] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HDR;
      sel     <= PW'(PORT_LOCAL);
      err_irq <= 1'b0;
    end else begin
      err_irq <= take && hdr_phase && !is_eop && dec_miss && !err_mask;
      if (!route_en) begin
        st <= ST_HDR;
      end else if (take && hdr_phase && !is_eop) begin
        st  <= ST_BODY;
        sel <= dec_dest;
      end else if (take && !hdr_phase && is_eop) begin
        st <= ST_HDR;
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    out_stage #(.W(TW)) u_stage (
      .clk(clk), .rst(rst), .load(load[p]), .din({in_kind, in_data}),
      .ready(oready[p]), .valid(ovalid[p]), .dout(odat[p])
    );
  end

  assign o0_valid  = ovalid[PORT_OTH0];
  assign o1_valid  = ovalid[PORT_OTH1];
  assign loc_valid = ovalid[PORT_LOCAL];
  assign {o0_kind, o0_data}   = odat[PORT_OTH0];
  assign {o1_kind, o1_data}   = odat[PORT_OTH1];
  assign {loc_kind, loc_data} = odat[PORT_LOCAL];

  // R2: one input token fills at most one output per cycle
  a_r2_single_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load));

  // R6: a pulse only follows a cycle in which the mask was clear
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> $past(!err_mask));

  // R7: an end marker in header position never raises the interrupt
  a_r7_empty_no_err: assert property (@(posedge clk) disable iff (rst)
    (route_en && st == ST_HDR && in_valid && in_kind != TK_DATA) |=> !err_irq);

  // R9: nothing enters while the selected output cannot take it
  a_r9_no_overrun: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && st == ST_BODY && route_en) |-> room[sel]);
endmodule

// File: tb/test_hdr_router.sv
module test_hdr_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_O0 = 8'h11, A_O1 = 8'h22, A_ND = 8'h33;

  logic clk = 0, rst = 1;
  logic route_en = 1, err_mask = 0;
  logic [7:0] addr_oth0 = A_O0, addr_oth1 = A_O1, addr_node = A_ND;
  logic in_valid = 0, in_ready;
  logic [1:0] in_kind = 0;
  logic [7:0] in_data = 0;
  logic o0_valid, o1_valid, loc_valid;
  logic o0_ready = 1, o1_ready = 1, loc_ready = 1;
  logic [1:0] o0_kind, o1_kind, loc_kind;
  logic [7:0] o0_data, o1_data, loc_data;
  logic err_irq;

  int checks = 0, fails = 0, errs = 0;
  logic [9:0] q0[$], q1[$], q2[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_router i_hdr_router (.*);

  always @(negedge clk) begin
    #1;
    if (o0_valid && o0_ready)   q0.push_back({o0_kind, o0_data});
    if (o1_valid && o1_ready)   q1.push_back({o1_kind, o1_data});
    if (loc_valid && loc_ready) q2.push_back({loc_kind, loc_data});
    if (err_irq) errs++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_q(input string tag, input logic [9:0] got[$], input logic [9:0] exp[$]);
    chk(got.size() == exp.size(), {tag, " count"}, got.size(), exp.size());
    foreach (exp[i])
      if (i < got.size()) chk(got[i] == exp[i], tag, got[i], exp[i]);
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] d);
    bit ok;
    in_valid = 1; in_kind = k; in_data = d;
    do begin
      #1 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear();
    q0.delete(); q1.delete(); q2.delete(); errs = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    #1 chk(!o0_valid && !o1_valid && !loc_valid && !err_irq, "R11 reset outputs", 0, 0);
    @(negedge clk); rst = 0;
    #1 chk(!o0_valid && !o1_valid && !loc_valid && !err_irq, "R11 after reset", 0, 0);
    @(negedge clk);
  endtask

  task automatic t_other_links();
    clear();
    send(2'b00, A_O0); send(2'b00, 8'h01); send(2'b00, 8'h02); send(2'b01, 8'h00);
    send(2'b00, A_O1); send(2'b00, 8'hA5); send(2'b10, 8'h00);
    settle();
    cmp_q("R3 R2 port0", q0, '{10'h001, 10'h002, 10'h100});
    cmp_q("R3 R2 port1", q1, '{10'h0A5, 10'h200});
    chk(q2.size() == 0 && errs == 0, "R3 no local/err", q2.size(), 0);
  endtask

  task automatic t_node();
    clear();
    send(2'b00, A_ND); send(2'b00, 8'h7E); send(2'b10, 8'h00);
    settle();
    cmp_q("R4 local", q2, '{10'h07E, 10'h200});
  endtask

  task automatic t_latency();
    clear();
    send(2'b00, A_O1);
    in_valid = 1; in_kind = 2'b00; in_data = 8'h3C;
    @(negedge clk); in_valid = 0;
    #1 chk(o1_valid && o1_data == 8'h3C, "R11 one-cycle latency", o1_data, 8'h3C);
    send(2'b01, 8'h00);
    settle();
  endtask

  task automatic t_miss(input bit mask);
    clear();
    err_mask = mask;
    send(2'b00, 8'h99);
    #1 chk(err_irq == !mask, mask ? "R6 no pulse" : "R5 pulse timing", err_irq, !mask);
    send(2'b00, 8'h44); send(2'b01, 8'h00);
    settle();
    cmp_q(mask ? "R6 local" : "R5 local", q2, '{10'h044, 10'h100});
    chk(errs == (mask ? 0 : 1), mask ? "R6 err count" : "R5 err count", errs, mask ? 0 : 1);
    err_mask = 0;
  endtask

  task automatic t_empty();
    clear();
    send(2'b01, 8'h00);
    send(2'b00, A_ND); send(2'b00, 8'h04); send(2'b01, 8'h00);
    settle();
    cmp_q("R7 empty dropped", q2, '{10'h004, 10'h100});
    chk(errs == 0, "R7 no error", errs, 0);
  endtask

  task automatic t_back_to_back();
    clear();
    send(2'b00, A_O1); send(2'b00, A_O0); send(2'b00, 8'h09); send(2'b01, 8'h00);
    send(2'b00, A_O0); send(2'b00, 8'h08); send(2'b10, 8'h00);
    settle();
    cmp_q("R8 first path", q1, '{10'h011, 10'h009, 10'h100});
    cmp_q("R8 new header", q0, '{10'h008, 10'h200});
  endtask

  task automatic t_priority();
    clear();
    addr_node = A_O0;
    send(2'b00, A_O0); send(2'b00, 8'h5A); send(2'b01, 8'h00);
    settle();
    cmp_q("R1 node wins", q2, '{10'h05A, 10'h100});
    chk(q0.size() == 0, "R1 port0 idle", q0.size(), 0);
    addr_node = A_ND; addr_oth1 = A_O0;
    clear();
    send(2'b00, A_O0); send(2'b00, 8'h6B); send(2'b01, 8'h00);
    settle();
    cmp_q("R1 oth0 over oth1", q0, '{10'h06B, 10'h100});
    addr_oth1 = A_O1;
  endtask

  task automatic t_backpressure();
    clear();
    o0_ready = 0;
    fork
      begin
        send(2'b00, A_O0); send(2'b00, 8'h05); send(2'b00, 8'h06); send(2'b01, 8'h00);
      end
      begin
        repeat (6) @(negedge clk);
        #2;
        chk(!in_ready, "R9 input stalled", in_ready, 0);
        chk(o0_valid && o0_data == 8'h05, "R9 output held", o0_data, 8'h05);
        @(negedge clk); o0_ready = 1;
      end
    join
    settle();
    cmp_q("R9 order kept", q0, '{10'h005, 10'h006, 10'h100});
  endtask

  task automatic t_disabled();
    clear();
    route_en = 0;
    settle();
    send(2'b00, A_O0); send(2'b00, 8'h01); send(2'b10, 8'h00);
    settle();
    cmp_q("R10 passthrough", q2, '{10'h011, 10'h001, 10'h200});
    chk(q0.size() == 0 && errs == 0, "R10 no routing", q0.size(), 0);
    route_en = 1;
    settle();
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_other_links();
    t_node();
    t_latency();
    t_miss(0);
    t_miss(1);
    t_empty();
    t_back_to_back();
    t_priority();
    t_backpressure();
    t_disabled();
    report();
  end
endmodule